// File: doc/BRIEF.md
# Multi-Colour Breathing Pattern Sequencer

This block times one LED breathing pattern from a 1 ms tick. A run starts with a start delay. Each enabled colour then pulses in turn: a rising ramp, a dwell at full brightness, a falling ramp and an off gap between pulses. A closing off time ends each pattern loop. Three nested counters shape a run. The innermost repeats a colour's pulse. The next repeats the full sweep over the enabled colours, a multi-pulse loop. The outermost repeats the whole pattern, starting-delay and off time included. At the end of a run the sequencer can park with the LED lit or dark. It can also ask a sibling sequencer to take over when the block works in combined RGB mode.

The block outputs an 8-bit brightness fraction and the index of the colour currently shown. An outer datapath scales that colour's per-channel levels by the fraction. The block also reports an encoded state byte for software to read and an active-low mark pin that brackets one chosen phase. A chip uses three copies, one per pattern, told apart by the `PAT_ID` parameter. The configuration fields are sampled when a commit pulse arrives. Software shutdown resets the sequencer to idle.

Top module: `breath_seq`

## Requirements
- R1: After reset and while idle, the state byte is 0x00, the level is 0, the colour output is 0, the mark pin is high and no chain request is raised.
- R2: Each phase lasts a number of ticks given by its 4-bit code: 0→40, 1→160, 2→310, 3→460, 4→610, 5→920, 6→1250, 7→1920, 8→2520, 9→3120, 10→3720, 11→5040, 12→6240, 13→7440, 14→8760, 15→9960. One pattern loop runs start delay, then the pulses, then off time. Each pulse runs rise, peak, fall, gap.
- R3: The state byte reads 0x90 in the start delay and 0x95 in the off time. Colour 1 (index 0) reads 0x91/0x92/0x93 for rise/peak/fall and 0xA4 in its gap. Colour 2 reads 0xA1/0xA2/0xA3 and 0xC4. Colour 3 reads 0xC1/0xC2/0xC3 and 0x94.
- R4: With the linear bit set, the level during a rise, e ticks into the phase, is within 1 of floor(e·256/D), where D is the phase length. A fall gives 255 minus that value. The peak gives 255. Start delay, gap and off time give 0.
- R5: With the linear bit clear, the level is floor((765·x² + 2·x³)/325125), where x is the linear level from R4.
- R6: Colour-enable bit i (bit 0 = colour 1) admits colour i+1. Enabled colours pulse in ascending order and disabled ones are skipped. The colour output reads 1 to 3 during a colour's phases and 0 otherwise.
- R7: Each colour's 2-bit repeat field (colour 1 in bits 1:0, colour 2 in 3:2, colour 3 in 5:4) gives its consecutive pulse count: 01→1, 10→2, 11→3.
- R8: The 4-bit multi-pulse count, 1 to 15, repeats the sweep over the enabled colours that many times within one pattern loop.
- R9: The 8-bit pattern loop field gives the number of pattern loops. That number is bits 6:0, multiplied by 16 when bit 7 is set.
- R10: A zero colour repeat code, zero multi-pulse count or zero pattern loop base makes that loop endless.
- R11: With hold enabled, a run does not return to idle. If hold-select is 1 it parks in the final peak (0x92-type code, level 255). If hold-select is 0 it parks in the final off time (0x95, level 0).
- R12: With RGB mode set, when a run ends without hold, a one-cycle chain request pulses in the same cycle the state byte becomes 0x00. It names the target pattern. For the default `PAT_ID`=2, next code 01 targets 1 and 10 targets 3. Code 11, or RGB mode clear, raises no request.
- R13: With marking enabled, the mark pin is low exactly while the selected phase runs. The 2-bit mark-phase field picks the phase: 00 = peak of the selected colour, 01 = gap of the selected colour, 1x = off time. The 2-bit mark colour field uses 00/01/10 for colours 1/2/3.
- R14: A commit pulse restarts the run from the start delay on the next cycle. While shutdown is high the state is 0x00 on the next cycle and commits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 1 ms time base strobe |
| sd_i | input | 1 | Software shutdown |
| start_i | input | 1 | Commit: sample configuration and restart |
| ts_code_i | input | 4 | Start delay code |
| rise_code_i | input | 4 | Rise ramp code |
| peak_code_i | input | 4 | Peak dwell code |
| fall_code_i | input | 4 | Fall ramp code |
| gap_code_i | input | 4 | Inter-pulse gap code |
| off_code_i | input | 4 | Off time code |
| col_en_i | input | 3 | Colour enables |
| col_rep_i | input | 6 | Per-colour repeat codes |
| pulse_loops_i | input | 4 | Multi-pulse loop count |
| pat_loops_i | input | 8 | Pattern loop field |
| hold_en_i | input | 1 | End-of-run hold enable |
| hold_on_i | input | 1 | Hold lit (1) or dark (0) |
| linear_i | input | 1 | Linear ramp (1) or gamma ramp (0) |
| rgb_mode_i | input | 1 | Combined RGB mode, allows chaining |
| next_sel_i | input | 2 | Chain target code |
| mark_en_i | input | 1 | Mark pin enable |
| mark_col_i | input | 2 | Colour the mark watches |
| mark_sel_i | input | 2 | Phase the mark watches |
| level_o | output | 8 | Brightness fraction |
| colour_o | output | 2 | Active colour, 0 when none |
| state_code_o | output | 8 | Encoded run state |
| mark_n_o | output | 1 | Active-low phase mark |
| chain_go_o | output | 1 | One-cycle chain request |
| chain_to_o | output | 2 | Chain target pattern number |

## Verification
Wrong nesting of the repeat counters shows at once in the state byte: a pulse too many or too few shifts every later code. The scoreboard therefore compares the whole code sequence and each dwell length, tick for tick, and reports the first code that arrives out of place. A wrong ramp reciprocal or gamma curve shows only in the level value partway through a ramp, so mid-ramp samples are checked against the formulas. Hold, chaining and mark errors appear within one cycle of the relevant phase boundary. The bench checks them at that boundary.

// File: rtl/breath_pkg.sv
package breath_pkg;

    localparam int CODE_W  = 4;
    localparam int DUR_W   = 14;
    localparam int RECIP_W = 20;
    localparam int LVL_W   = 8;
    localparam int PROD_W  = DUR_W + RECIP_W;
    localparam int PL_W    = 11;
    localparam int MP_W    = 4;
    localparam int NCOL    = 3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_RISE, PH_PEAK, PH_FALL, PH_GAP, PH_OFF
    } phase_e;

    typedef struct packed {
        logic [CODE_W-1:0] ts;
        logic [CODE_W-1:0] t1;
        logic [CODE_W-1:0] t2;
        logic [CODE_W-1:0] t3;
        logic [CODE_W-1:0] tp;
        logic [CODE_W-1:0] t4;
        logic [NCOL-1:0]   en;
        logic [2*NCOL-1:0] rep;
        logic [MP_W-1:0]   mp;
        logic [7:0]        pl;
        logic              hold_en;
        logic              hold_on;
        logic              linear;
        logic              rgb;
        logic [1:0]        nxt;
    } cfg_t;

    // phase length in ticks
    function automatic logic [DUR_W-1:0] dur_ticks(input logic [CODE_W-1:0] c);
        case (c)
            4'd0:  return 14'd40;
            4'd1:  return 14'd160;
            4'd2:  return 14'd310;
            4'd3:  return 14'd460;
            4'd4:  return 14'd610;
            4'd5:  return 14'd920;
            4'd6:  return 14'd1250;
            4'd7:  return 14'd1920;
            4'd8:  return 14'd2520;
            4'd9:  return 14'd3120;
            4'd10: return 14'd3720;
            4'd11: return 14'd5040;
            4'd12: return 14'd6240;
            4'd13: return 14'd7440;
            4'd14: return 14'd8760;
            default: return 14'd9960;
        endcase
    endfunction

    // floor(2^24 / ticks): ramp = (elapsed * recip) >> 16
    function automatic logic [RECIP_W-1:0] ramp_recip(input logic [CODE_W-1:0] c);
        case (c)
            4'd0:  return 20'd419430;
            4'd1:  return 20'd104857;
            4'd2:  return 20'd54120;
            4'd3:  return 20'd36472;
            4'd4:  return 20'd27503;
            4'd5:  return 20'd18236;
            4'd6:  return 20'd13421;
            4'd7:  return 20'd8738;
            4'd8:  return 20'd6657;
            4'd9:  return 20'd5377;
            4'd10: return 20'd4510;
            4'd11: return 20'd3328;
            4'd12: return 20'd2688;
            4'd13: return 20'd2255;
            4'd14: return 20'd1915;
            default: return 20'd1684;
        endcase
    endfunction

    // 0.6*u^2 + 0.4*u^3 blend standing in for a 2.4 power curve
    function automatic logic [LVL_W-1:0] gamma_shape(input logic [LVL_W-1:0] x);
        logic [31:0] xs, sq, cu, num;
        xs  = {24'd0, x};
        sq  = xs * xs;
        cu  = sq * xs;
        num = 32'd765 * sq + 32'd2 * cu;
        return LVL_W'(num / 32'd325125);
    endfunction

    // lowest enabled colour index >= from; returns {found, index}
    function automatic logic [2:0] colour_search(input logic [NCOL-1:0] en,
                                                 input logic [2:0] from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (en[i] && (i >= int'(from))) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

    // {valid, target pattern number}
    function automatic logic [2:0] chain_target(input int pat, input logic [1:0] sel);
        logic [2:0] r;
        r = 3'b000;
        case (pat)
            1: if (sel == 2'b01) r = {1'b1, 2'd2};
            2: if (sel == 2'b01) r = {1'b1, 2'd1};
               else if (sel == 2'b10) r = {1'b1, 2'd3};
            default: if (sel == 2'b01) r = {1'b1, 2'd1};
                     else if (sel == 2'b10) r = {1'b1, 2'd2};
        endcase
        return r;
    endfunction

    function automatic logic [7:0] state_byte(input phase_e ph, input logic [1:0] c);
        logic [7:0] base;
        base = (c == 2'd0) ? 8'h90 : (c == 2'd1) ? 8'hA0 : 8'hC0;
        case (ph)
            PH_START: return 8'h90;
            PH_OFF:   return 8'h95;
            PH_RISE:  return base | 8'h01;
            PH_PEAK:  return base | 8'h02;
            PH_FALL:  return base | 8'h03;
            PH_GAP:   return (c == 2'd0) ? 8'hA4 : (c == 2'd1) ? 8'hC4 : 8'h94;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/breath_timer.sv
module breath_timer
    import breath_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                clr_i,
    input  logic                tick_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [DUR_W-1:0]    elapsed_o,
    output logic                done_o
);
    logic [DUR_W-1:0] elapsed_q;
    logic [DUR_W-1:0] dur;

    assign dur       = dur_ticks(code_i);
    assign done_o    = tick_i && (elapsed_q == dur - DUR_W'(1));
    assign elapsed_o = elapsed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)  elapsed_q <= '0;
        else if (done_o)     elapsed_q <= '0;
        else if (tick_i)     elapsed_q <= elapsed_q + DUR_W'(1);
    end

    // R2
    elapsed_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        elapsed_q < dur);
endmodule

// File: rtl/breath_shaper.sv
module breath_shaper
    import breath_pkg::*;
(
    input  phase_e              phase_i,
    input  logic [DUR_W-1:0]    elapsed_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic                linear_i,
    output logic [LVL_W-1:0]    level_o
);
    logic [PROD_W-1:0] prod;
    logic [LVL_W-1:0]  ramp;
    logic [LVL_W-1:0]  lin;

    assign prod = PROD_W'(elapsed_i) * PROD_W'(ramp_recip(code_i));
    assign ramp = (prod[PROD_W-1:24] != '0) ? {LVL_W{1'b1}} : prod[23:16];

    always_comb begin
        case (phase_i)
            PH_RISE: lin = ramp;
            PH_PEAK: lin = {LVL_W{1'b1}};
            PH_FALL: lin = {LVL_W{1'b1}} - ramp;
            default: lin = '0;
        endcase
        level_o = linear_i ? lin : gamma_shape(lin);
    end
endmodule

// File: rtl/breath_ctrl.sv
module breath_ctrl
    import breath_pkg::*;
#(
    parameter int PAT_ID = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sd_i,
    input  logic                start_i,
    input  cfg_t                cfg_i,
    input  logic                done_i,
    output phase_e              phase_o,
    output logic [1:0]          col_o,
    output logic [CODE_W-1:0]   code_o,
    output logic                clr_o,
    output logic                linear_o,
    output logic                chain_go_o,
    output logic [1:0]          chain_to_o
);
    phase_e           phase_q, n_phase;
    cfg_t             cfg_q;
    logic [1:0]       col_q, n_col;
    logic [1:0]       rep_q, n_rep;
    logic [MP_W-1:0]  mp_q, n_mp;
    logic [PL_W-1:0]  pl_q, n_pl;
    logic             held_q, n_held;
    logic             chain_go_q, n_chain;
    logic [1:0]       chain_to_q;

    logic             start_ok;
    logic [1:0]       rep_lim;
    logic [PL_W-1:0]  pl_lim;
    logic             rep_last, mp_last, pl_last, final_pulse;
    logic [2:0]       first_c, next_c, tgt;

    assign start_ok = start_i && !sd_i;

    always_comb begin
        case (col_q)
            2'd0:    rep_lim = cfg_q.rep[1:0];
            2'd1:    rep_lim = cfg_q.rep[3:2];
            default: rep_lim = cfg_q.rep[5:4];
        endcase
    end

    assign pl_lim      = cfg_q.pl[7] ? {cfg_q.pl[6:0], 4'b0000} : {4'b0000, cfg_q.pl[6:0]};
    assign rep_last    = (rep_lim != 2'd0) && (rep_q + 2'd1 == rep_lim);
    assign mp_last     = (cfg_q.mp != '0) && (mp_q + MP_W'(1) == cfg_q.mp);
    assign pl_last     = (pl_lim != '0) && (pl_q + PL_W'(1) == pl_lim);
    assign first_c     = colour_search(cfg_q.en, 3'd0);
    assign next_c      = colour_search(cfg_q.en, {1'b0, col_q} + 3'd1);
    assign final_pulse = rep_last && !next_c[2] && mp_last && pl_last;
    assign tgt         = chain_target(PAT_ID, cfg_q.nxt);

    always_comb begin
        n_phase = phase_q;
        n_col   = col_q;
        n_rep   = rep_q;
        n_mp    = mp_q;
        n_pl    = pl_q;
        n_held  = held_q;
        n_chain = 1'b0;
        if (sd_i) begin
            n_phase = PH_IDLE;
            n_col = '0; n_rep = '0; n_mp = '0; n_pl = '0; n_held = 1'b0;
        end else if (start_i) begin
            n_phase = PH_START;
            n_col = '0; n_rep = '0; n_mp = '0; n_pl = '0; n_held = 1'b0;
        end else if (done_i && !held_q) begin
            case (phase_q)
                PH_START: begin
                    if (first_c[2]) begin
                        n_phase = PH_RISE;
                        n_col   = first_c[1:0];
                        n_rep   = '0;
                    end else begin
                        n_phase = PH_OFF;
                    end
                end
                PH_RISE: n_phase = PH_PEAK;
                PH_PEAK: begin
                    if (cfg_q.hold_en && cfg_q.hold_on && final_pulse) n_held = 1'b1;
                    else n_phase = PH_FALL;
                end
                PH_FALL: n_phase = PH_GAP;
                PH_GAP: begin
                    if (!rep_last) begin
                        n_rep = rep_q + 2'd1;
                        n_phase = PH_RISE;
                    end else if (next_c[2]) begin
                        n_col = next_c[1:0];
                        n_rep = '0;
                        n_phase = PH_RISE;
                    end else if (!mp_last) begin
                        n_mp = mp_q + MP_W'(1);
                        n_col = first_c[1:0];
                        n_rep = '0;
                        n_phase = PH_RISE;
                    end else begin
                        n_mp = '0;
                        n_phase = PH_OFF;
                    end
                end
                PH_OFF: begin
                    if (!pl_last) begin
                        n_pl = pl_q + PL_W'(1);
                        n_phase = PH_START;
                    end else if (cfg_q.hold_en && !cfg_q.hold_on) begin
                        n_held = 1'b1;
                    end else begin
                        n_phase = PH_IDLE;
                        n_chain = cfg_q.rgb && tgt[2];
                    end
                end
                default: n_phase = phase_q;
            endcase
        end
    end

    always_comb begin
        case (phase_q)
            PH_RISE: code_o = cfg_q.t1;
            PH_PEAK: code_o = cfg_q.t2;
            PH_FALL: code_o = cfg_q.t3;
            PH_GAP:  code_o = cfg_q.tp;
            PH_OFF:  code_o = cfg_q.t4;
            default: code_o = cfg_q.ts;
        endcase
    end

    assign clr_o = start_ok || (n_phase != phase_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q    <= PH_IDLE;
            cfg_q      <= '0;
            col_q      <= '0;
            rep_q      <= '0;
            mp_q       <= '0;
            pl_q       <= '0;
            held_q     <= 1'b0;
            chain_go_q <= 1'b0;
            chain_to_q <= '0;
        end else begin
            phase_q    <= n_phase;
            col_q      <= n_col;
            rep_q      <= n_rep;
            mp_q       <= n_mp;
            pl_q       <= n_pl;
            held_q     <= n_held;
            chain_go_q <= n_chain;
            chain_to_q <= n_chain ? tgt[1:0] : 2'd0;
            if (start_ok) cfg_q <= cfg_i;
        end
    end

    assign phase_o    = phase_q;
    assign col_o      = col_q;
    assign linear_o   = cfg_q.linear;
    assign chain_go_o = chain_go_q;
    assign chain_to_o = chain_to_q;

    // R7
    rep_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rep_lim != 2'd0) |-> (rep_q < rep_lim));
    // R8
    mp_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_q.mp != '0) |-> (mp_q < cfg_q.mp));
    // R9
    pl_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pl_lim != '0) |-> (pl_q < pl_lim));
endmodule

// File: rtl/breath_seq.sv
module breath_seq
    import breath_pkg::*;
#(
    parameter int PAT_ID = 2
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    input  logic        sd_i,
    input  logic        start_i,
    input  logic [3:0]  ts_code_i,
    input  logic [3:0]  rise_code_i,
    input  logic [3:0]  peak_code_i,
    input  logic [3:0]  fall_code_i,
    input  logic [3:0]  gap_code_i,
    input  logic [3:0]  off_code_i,
    input  logic [2:0]  col_en_i,
    input  logic [5:0]  col_rep_i,
    input  logic [3:0]  pulse_loops_i,
    input  logic [7:0]  pat_loops_i,
    input  logic        hold_en_i,
    input  logic        hold_on_i,
    input  logic        linear_i,
    input  logic        rgb_mode_i,
    input  logic [1:0]  next_sel_i,
    input  logic        mark_en_i,
    input  logic [1:0]  mark_col_i,
    input  logic [1:0]  mark_sel_i,
    output logic [7:0]  level_o,
    output logic [1:0]  colour_o,
    output logic [7:0]  state_code_o,
    output logic        mark_n_o,
    output logic        chain_go_o,
    output logic [1:0]  chain_to_o
);
    cfg_t              cfg_in;
    phase_e            phase;
    logic [1:0]        col;
    logic [CODE_W-1:0] code;
    logic              clr, done, lin_sel;
    logic [DUR_W-1:0]  elapsed;
    logic              in_colour;

    assign cfg_in.ts      = ts_code_i;
    assign cfg_in.t1      = rise_code_i;
    assign cfg_in.t2      = peak_code_i;
    assign cfg_in.t3      = fall_code_i;
    assign cfg_in.tp      = gap_code_i;
    assign cfg_in.t4      = off_code_i;
    assign cfg_in.en      = col_en_i;
    assign cfg_in.rep     = col_rep_i;
    assign cfg_in.mp      = pulse_loops_i;
    assign cfg_in.pl      = pat_loops_i;
    assign cfg_in.hold_en = hold_en_i;
    assign cfg_in.hold_on = hold_on_i;
    assign cfg_in.linear  = linear_i;
    assign cfg_in.rgb     = rgb_mode_i;
    assign cfg_in.nxt     = next_sel_i;

    breath_ctrl #(.PAT_ID(PAT_ID)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sd_i       (sd_i),
        .start_i    (start_i),
        .cfg_i      (cfg_in),
        .done_i     (done),
        .phase_o    (phase),
        .col_o      (col),
        .code_o     (code),
        .clr_o      (clr),
        .linear_o   (lin_sel),
        .chain_go_o (chain_go_o),
        .chain_to_o (chain_to_o)
    );

    breath_timer u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (clr),
        .tick_i    (tick_i),
        .code_i    (code),
        .elapsed_o (elapsed),
        .done_o    (done)
    );

    breath_shaper u_shaper (
        .phase_i   (phase),
        .elapsed_i (elapsed),
        .code_i    (code),
        .linear_i  (lin_sel),
        .level_o   (level_o)
    );

    assign in_colour    = (phase == PH_RISE) || (phase == PH_PEAK) ||
                          (phase == PH_FALL) || (phase == PH_GAP);
    assign colour_o     = in_colour ? col + 2'd1 : 2'd0;
    assign state_code_o = state_byte(phase, col);

    always_comb begin
        mark_n_o = 1'b1;
        if (mark_en_i) begin
            if (mark_sel_i[1])
                mark_n_o = (phase != PH_OFF);
            else if (mark_sel_i[0])
                mark_n_o = !((phase == PH_GAP) && (col == mark_col_i));
            else
                mark_n_o = !((phase == PH_PEAK) && (col == mark_col_i));
        end
    end

    // R14
    sd_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sd_i |=> (state_code_o == 8'h00));
    // R4
    dark_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_code_o != 8'h00) && ((state_code_o[3:0] == 4'h0) ||
         (state_code_o[3:0] == 4'h4) || (state_code_o[3:0] == 4'h5))) |-> (level_o == 8'd0));
    // R4
    peak_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_code_o[3:0] == 4'h2) |-> (level_o == 8'hFF));
    // R12
    chain_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        chain_go_o |-> ((state_code_o == 8'h00) && ($past(state_code_o) == 8'h95)));
    // R13
    mark_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mark_n_o |-> ((state_code_o[3:0] == 4'h2) || (state_code_o[3:0] == 4'h4) ||
                       (state_code_o == 8'h95)));
endmodule

// File: tb/tb_breath_seq.sv
module tb_breath_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, sd = 1'b0, start = 1'b0;
    logic [3:0] ts_c = 0, t1_c = 0, t2_c = 0, t3_c = 0, tp_c = 0, t4_c = 0;
    logic [2:0] en = 3'b001;
    logic [5:0] rep = 6'b000001;
    logic [3:0] mp = 4'd1;
    logic [7:0] pl = 8'd1;
    logic hold_en = 0, hold_on = 0, linear = 1, rgb = 0;
    logic [1:0] nxt = 0;
    logic mark_en = 0;
    logic [1:0] mark_col = 0, mark_sel = 0;
    logic [7:0] level, scode;
    logic [1:0] colour, chain_to;
    logic mark_n, chain_go;

    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    breath_seq dut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .sd_i(sd), .start_i(start),
        .ts_code_i(ts_c), .rise_code_i(t1_c), .peak_code_i(t2_c), .fall_code_i(t3_c),
        .gap_code_i(tp_c), .off_code_i(t4_c), .col_en_i(en), .col_rep_i(rep),
        .pulse_loops_i(mp), .pat_loops_i(pl), .hold_en_i(hold_en), .hold_on_i(hold_on),
        .linear_i(linear), .rgb_mode_i(rgb), .next_sel_i(nxt), .mark_en_i(mark_en),
        .mark_col_i(mark_col), .mark_sel_i(mark_sel), .level_o(level), .colour_o(colour),
        .state_code_o(scode), .mark_n_o(mark_n), .chain_go_o(chain_go), .chain_to_o(chain_to)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ms(input logic [3:0] c);
        case (c)
            0: return 40;    1: return 160;   2: return 310;   3: return 460;
            4: return 610;   5: return 920;   6: return 1250;  7: return 1920;
            8: return 2520;  9: return 3120;  10: return 3720; 11: return 5040;
            12: return 6240; 13: return 7440; 14: return 8760; default: return 9960;
        endcase
    endfunction

    function automatic int gam(input int x);
        return (765 * x * x + 2 * x * x * x) / 325125;
    endfunction

    // scoreboard
    typedef struct { logic [7:0] code; int len; } item_t;
    item_t exp_q[$];
    bit sb_on = 0;
    logic [7:0] cur = 8'h00;
    int cur_len = 0, cur_exp = 0;

    task automatic push(input logic [7:0] c, input int l);
        item_t it;
        it.code = c; it.len = l;
        exp_q.push_back(it);
    endtask

    // expected code sequence per R2, R3, R6-R9
    task automatic model_run();
        logic [7:0] rise_c [3] = '{8'h91, 8'hA1, 8'hC1};
        logic [7:0] gap_c [3]  = '{8'hA4, 8'hC4, 8'h94};
        int nl;
        nl = pl[7] ? 16 * int'(pl[6:0]) : int'(pl[6:0]);
        for (int l = 0; l < nl; l++) begin
            push(8'h90, ms(ts_c));
            for (int m = 0; m < int'(mp); m++) begin
                for (int c = 0; c < 3; c++) begin
                    if (en[c]) begin
                        for (int r = 0; r < int'(rep[2*c +: 2]); r++) begin
                            push(rise_c[c], ms(t1_c));
                            push(rise_c[c] + 8'd1, ms(t2_c));
                            push(rise_c[c] + 8'd2, ms(t3_c));
                            push(gap_c[c], ms(tp_c));
                        end
                    end
                end
            end
            push(8'h95, ms(t4_c));
        end
        push(8'h00, 0);
    endtask

    always @(negedge clk) begin
        if (sb_on) begin
            if (scode != cur) begin
                if (cur_exp > 0)
                    chk("R2 dwell", cur_len == cur_exp, cur_len, cur_exp);
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected code", 1'b0, int'(scode), -1);
                    cur_exp = 0;
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk("R3 code sequence (R6 R7 R8 R9)", scode == it.code, int'(scode), int'(it.code));
                    cur_exp = it.len;
                end
                cur = scode;
                cur_len = 1;
            end else begin
                cur_len++;
            end
        end
    end

    task automatic commit();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic sb_run(output bit go_seen, output logic [1:0] to_seen);
        model_run();
        cur = 8'h00; cur_len = 0; cur_exp = 0;
        sb_on = 1'b1;
        commit();
        while (scode != 8'h00) @(negedge clk);
        go_seen = chain_go;
        to_seen = chain_to;
        @(negedge clk);
        chk("R12 pulse one cycle", chain_go == 1'b0, int'(chain_go), 0);
        sb_on = 1'b0;
        chk("R9 all expected codes seen", exp_q.size() == 0, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic base_cfg();
        ts_c = 0; t1_c = 0; t2_c = 0; t3_c = 0; tp_c = 0; t4_c = 0;
        en = 3'b001; rep = 6'b000001; mp = 4'd1; pl = 8'd1;
        hold_en = 0; hold_on = 0; linear = 1; rgb = 0; nxt = 0;
        mark_en = 0; mark_col = 0; mark_sel = 0;
    endtask

    task automatic mark_scan(input logic [7:0] want, input int exp_low, input string req);
        int mism, low;
        mism = 0; low = 0;
        commit();
        for (int i = 0; i < 450; i++) begin
            if (!mark_n) low++;
            if ((!mark_n) != (mark_en && scode == want)) mism++;
            @(negedge clk);
        end
        chk(req, mism == 0, mism, 0);
        chk(req, low == exp_low, low, exp_low);
    endtask

    initial begin
        bit g;
        logic [1:0] t;
        int e;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 idle code", scode == 8'h00, int'(scode), 0);
        chk("R1 idle level", level == 8'd0, int'(level), 0);
        chk("R1 idle colour", colour == 2'd0, int'(colour), 0);
        chk("R1 mark high", mark_n == 1'b1, int'(mark_n), 1);
        chk("R1 no chain", chain_go == 1'b0, int'(chain_go), 0);

        // R2 R3 R6 R7: mixed codes, colours 1 and 3
        base_cfg();
        ts_c = 1; t2_c = 2; tp_c = 1; en = 3'b101; rep = 6'b100001;
        sb_run(g, t);
        chk("R12 no chain without RGB", g == 1'b0, int'(g), 0);

        // R7 R8 R9: two colours, repeats, two multi-pulse loops, two pattern loops
        base_cfg();
        en = 3'b011; rep = 6'b000110; mp = 4'd2; pl = 8'd2;
        sb_run(g, t);

        // R9: scaled pattern loop count, 1 x 16
        base_cfg();
        pl = 8'h81;
        sb_run(g, t);

        // R12 chaining
        base_cfg(); rgb = 1; nxt = 2'b01;
        sb_run(g, t);
        chk("R12 chain raised", g == 1'b1, int'(g), 1);
        chk("R12 chain target 1", t == 2'd1, int'(t), 1);
        nxt = 2'b10;
        sb_run(g, t);
        chk("R12 chain raised", g == 1'b1, int'(g), 1);
        chk("R12 chain target 3", t == 2'd3, int'(t), 3);
        nxt = 2'b11;
        sb_run(g, t);
        chk("R12 code 11 stops", g == 1'b0, int'(g), 0);

        // R4 linear ramp: rise/fall 160 ticks
        base_cfg(); t1_c = 1; t3_c = 1;
        commit();
        chk("R4 start level", level == 0 && scode == 8'h90, int'(level), 0);
        repeat (120) @(negedge clk);
        e = (80 * 256) / 160;
        chk("R4 rise midpoint", int'(level) >= e - 1 && int'(level) <= e + 1, int'(level), e);
        chk("R6 colour output", colour == 2'd1, int'(colour), 1);
        repeat (100) @(negedge clk);
        chk("R4 peak level", level == 8'd255, int'(level), 255);
        repeat (60) @(negedge clk);
        e = 255 - (40 * 256) / 160;
        chk("R4 fall level", int'(level) >= e - 1 && int'(level) <= e + 1, int'(level), e);
        repeat (140) @(negedge clk);
        chk("R4 gap dark", level == 8'd0 && scode == 8'hA4, int'(level), 0);
        repeat (100) @(negedge clk);

        // R5 gamma ramp
        linear = 0;
        commit();
        repeat (120) @(negedge clk);
        e = gam((80 * 256) / 160);
        chk("R5 gamma rise", int'(level) >= e - 2 && int'(level) <= e + 2, int'(level), e);
        repeat (160) @(negedge clk);
        e = gam(255 - (40 * 256) / 160);
        chk("R5 gamma fall", int'(level) >= e - 2 && int'(level) <= e + 2, int'(level), e);
        repeat (220) @(negedge clk);

        // R10 endless colour repeat, then R14 shutdown
        base_cfg(); rep = 6'b000000;
        commit();
        repeat (3000) @(negedge clk);
        chk("R10 endless repeat still running", scode != 8'h00 && scode != 8'h95, int'(scode), 1);
        sd = 1'b1;
        @(negedge clk);
        chk("R14 shutdown clears", scode == 8'h00 && level == 8'd0, int'(scode), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R14 commit ignored in shutdown", scode == 8'h00, int'(scode), 0);
        sd = 1'b0;

        // R10 endless pattern loop
        base_cfg(); pl = 8'h00;
        commit();
        repeat (3000) @(negedge clk);
        chk("R10 endless pattern loop running", scode != 8'h00, int'(scode), 1);
        sd = 1'b1; @(negedge clk); sd = 1'b0;

        // R11 hold lit
        base_cfg(); hold_en = 1; hold_on = 1;
        commit();
        repeat (1000) @(negedge clk);
        chk("R11 hold lit code", scode == 8'h92, int'(scode), 'h92);
        chk("R11 hold lit level", level == 8'd255, int'(level), 255);
        // R14 commit restarts
        commit();
        chk("R14 restart at start delay", scode == 8'h90, int'(scode), 'h90);
        // R11 hold dark
        hold_on = 0;
        commit();
        repeat (1000) @(negedge clk);
        chk("R11 hold dark code", scode == 8'h95, int'(scode), 'h95);
        chk("R11 hold dark level", level == 8'd0, int'(level), 0);
        sd = 1'b1; @(negedge clk); sd = 1'b0;

        // R13 mark
        base_cfg(); en = 3'b011; rep = 6'b000101;
        mark_en = 1; mark_col = 2'b01; mark_sel = 2'b00;
        mark_scan(8'hA2, 40, "R13 mark colour 2 peak");
        mark_sel = 2'b10;
        mark_scan(8'h95, 40, "R13 mark off time");
        mark_col = 2'b00; mark_sel = 2'b01;
        mark_scan(8'hA4, 40, "R13 mark colour 1 gap");
        mark_en = 0;
        mark_scan(8'hA4, 0, "R13 mark disabled");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule